// File: doc/BRIEF.md
# Handshake Modulo-6 Event Counter

This block counts four-phase request/acknowledge handshakes that arrive on one incoming channel. It answers each one on one of two outgoing channels. The first five incoming requests of every group are passed on to the tick channel. The sixth is passed on to the wrap channel, and then the group starts again, with no end. No data moves through the block, so the channels are plain request/acknowledge level pairs and not valid/ready streams. Back-pressure comes from the handshake itself: the block holds its outgoing request until the far side acknowledges, and it holds its incoming acknowledge until the requester withdraws.

The count is a ring of stage cells in one-hot form, with one cell for each position in the group and a single token. For each incoming request, the controller raises the selected outgoing request. It waits for that channel's acknowledge, withdraws the request, and waits for the acknowledge to fall again. Only then does it move the token one cell and acknowledge the incoming channel. The incoming acknowledge is released once the incoming request falls. The ring length is a parameter whose default is six.

Top module: `mod6_hs_counter`

## Requirements
- R1: After reset (active-low `rst_n`, synchronous), `in_ack`, `tick_req` and `wrap_req` are low, and the token sits in the first cell, so the next five requests go to the tick channel.
- R2: Incoming requests 1 to 5 of each group of six are each answered by exactly one tick handshake and no wrap handshake.
- R3: The sixth incoming request of each group is answered by exactly one wrap handshake and no tick handshake, and the next request starts a new group on the tick channel.
- R4: When the block is idle and samples `in_req` high at a clock edge, the selected outgoing request is high after that edge. `tick_req` and `wrap_req` are never high together.
- R5: An outgoing request stays high while its acknowledge is low. It is low after the first edge that samples its acknowledge high.
- R6: After an outgoing request falls, `in_ack` rises at the first edge that samples that channel's acknowledge low. The token moves one cell at that same edge and at no other time.
- R7: `in_ack` stays high while `in_req` is high, and it is low after the first edge that samples `in_req` low.
- R8: An acknowledge on the tick or wrap channel while no outgoing request is pending changes neither the outputs nor the count.
- R9: Exactly one stage cell holds the token in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_req | input | 1 | Incoming event request |
| in_ack | output | 1 | Incoming event acknowledge |
| tick_req | output | 1 | Ordinary outgoing request (events 1 to 5) |
| tick_ack | input | 1 | Ordinary outgoing acknowledge |
| wrap_req | output | 1 | Carry outgoing request (event 6) |
| wrap_ack | input | 1 | Carry outgoing acknowledge |

## Verification
The block is first driven with responders that acknowledge at once. This separates a token that moves too early or too late from one that moves correctly, because every phase boundary then falls on adjacent edges. It is then driven with acknowledge and withdrawal delays that differ from one handshake to the next. These show whether each wait is tied to the right level of the right signal, and not to a fixed cycle count. More than two full groups are run, so a wrong ring length or a missing wrap-around shows up in the order of the channels. Stray acknowledges on both outgoing channels while the block is idle test that no pending state is invented.

// File: rtl/mod6_hs_pkg.sv
package mod6_hs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_OUT_HI = 2'd1,
    PH_OUT_LO = 2'd2,
    PH_DONE   = 2'd3
  } hs_phase_e;
endpackage

// File: rtl/mod6_stage_cell.sv
module mod6_stage_cell #(
  parameter bit HOLD_AT_RESET = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  input  logic tok_prev,
  output logic tok_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       tok_q <= HOLD_AT_RESET;
    else if (advance) tok_q <= tok_prev;
  end
endmodule

// File: rtl/mod6_token_ring.sv
module mod6_token_ring #(
  parameter int NUM_STAGES = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  advance,
  output logic [NUM_STAGES-1:0] token,
  output logic                  at_last
);
  localparam int LAST = NUM_STAGES - 1;

  for (genvar gi = 0; gi < NUM_STAGES; gi++) begin : g_cell
    if (gi == 0) begin : g_head
      mod6_stage_cell #(.HOLD_AT_RESET(1'b1)) u_cell (
        .clk(clk), .rst_n(rst_n), .advance(advance),
        .tok_prev(token[LAST]), .tok_q(token[gi])
      );
    end else begin : g_body
      mod6_stage_cell #(.HOLD_AT_RESET(1'b0)) u_cell (
        .clk(clk), .rst_n(rst_n), .advance(advance),
        .tok_prev(token[gi-1]), .tok_q(token[gi])
      );
    end
  end

  assign at_last = token[LAST];
endmodule

// File: rtl/mod6_phase_ctrl.sv
module mod6_phase_ctrl
  import mod6_hs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_req,
  input  logic sel_wrap,
  input  logic tick_ack,
  input  logic wrap_ack,
  output logic in_ack,
  output logic tick_req,
  output logic wrap_req,
  output logic advance
);
  hs_phase_e phase_q, phase_d;
  logic      route_wrap_q;
  logic      sel_ack;

  assign sel_ack = route_wrap_q ? wrap_ack : tick_ack;

  always_comb begin
    phase_d = phase_q;
    advance = 1'b0;
    unique case (phase_q)
      PH_IDLE:   if (in_req)   phase_d = PH_OUT_HI;
      PH_OUT_HI: if (sel_ack)  phase_d = PH_OUT_LO;
      PH_OUT_LO: if (!sel_ack) begin
                   phase_d = PH_DONE;
                   advance = 1'b1;
                 end
      PH_DONE:   if (!in_req)  phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q      <= PH_IDLE;
      route_wrap_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (phase_q == PH_IDLE && in_req) route_wrap_q <= sel_wrap;
    end
  end

  assign tick_req = (phase_q == PH_OUT_HI) && !route_wrap_q;
  assign wrap_req = (phase_q == PH_OUT_HI) &&  route_wrap_q;
  assign in_ack   = (phase_q == PH_DONE);
endmodule

// File: rtl/mod6_hs_counter.sv
module mod6_hs_counter #(
  parameter int NUM_STAGES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_req,
  output logic in_ack,
  output logic tick_req,
  input  logic tick_ack,
  output logic wrap_req,
  input  logic wrap_ack
);
  logic [NUM_STAGES-1:0] token;
  logic                  at_last;
  logic                  advance;

  mod6_token_ring #(.NUM_STAGES(NUM_STAGES)) u_ring (
    .clk(clk), .rst_n(rst_n), .advance(advance),
    .token(token), .at_last(at_last)
  );

  mod6_phase_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .sel_wrap(at_last),
    .tick_ack(tick_ack), .wrap_ack(wrap_ack),
    .in_ack(in_ack), .tick_req(tick_req), .wrap_req(wrap_req),
    .advance(advance)
  );
endmodule

// File: rtl/mod6_hs_counter_chk.sv
module mod6_hs_counter_chk #(
  parameter int NUM_STAGES = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_req,
  input logic                  in_ack,
  input logic                  tick_req,
  input logic                  tick_ack,
  input logic                  wrap_req,
  input logic                  wrap_ack,
  input logic [NUM_STAGES-1:0] token
);
  p_one_token_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(token) == 1);

  p_excl_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_req && wrap_req));

  p_tick_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_req && !tick_ack |=> tick_req);

  p_tick_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_req && tick_ack |=> !tick_req);

  p_wrap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_req && !wrap_ack |=> wrap_req);

  p_wrap_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_req && wrap_ack |=> !wrap_req);

  p_ack_after_rtz_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ack) |-> !tick_req && !wrap_req && !$past(tick_ack) && !$past(wrap_ack));

  p_token_moves_with_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(token) |-> $rose(in_ack));

  p_ack_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack && in_req |=> in_ack);

  p_ack_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack && !in_req |=> !in_ack);
endmodule

bind mod6_hs_counter mod6_hs_counter_chk #(.NUM_STAGES(NUM_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_ack(in_ack),
  .tick_req(tick_req), .tick_ack(tick_ack),
  .wrap_req(wrap_req), .wrap_ack(wrap_ack), .token(token)
);

// File: tb/mod6_hs_counter_test.sv
module mod6_hs_counter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_req = 1'b0, tick_ack = 1'b0, wrap_ack = 1'b0;
  logic in_ack, tick_req, wrap_req;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  int st = 0;
  int cnt = 0;
  int events = 0;

  always #10 clk = ~clk;

  mod6_hs_counter #(.NUM_STAGES(6)) uut (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_ack(in_ack),
    .tick_req(tick_req), .tick_ack(tick_ack),
    .wrap_req(wrap_req), .wrap_ack(wrap_ack)
  );

  // Behavioural reference: handshake phase number and event count modulo 6.
  always @(posedge clk) begin
    if (!rst_n) begin
      st <= 0; cnt <= 0;
    end else begin
      case (st)
        0: if (in_req) st <= 1;
        1: if ((cnt == 5) ? wrap_ack : tick_ack) st <= 2;
        2: if (!((cnt == 5) ? wrap_ack : tick_ack)) begin
             st <= 3; cnt <= (cnt + 1) % 6;
           end
        default: if (!in_req) st <= 0;
      endcase
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check("R4/R5 tick_req", tick_req, st == 1 && cnt != 5);
      check("R3/R5 wrap_req", wrap_req, st == 1 && cnt == 5);
      check("R6/R7 in_ack", in_ack, st == 3);
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  task automatic one_event(input int d_ack, input int d_rtz, input int d_wd);
    logic got_wrap;
    logic exp_wrap;
    exp_wrap = (events % 6) == 5;
    in_req = 1'b1;
    @(negedge clk);
    while (!tick_req && !wrap_req) @(negedge clk);
    got_wrap = wrap_req;
    if (exp_wrap) check("R3 channel is wrap", got_wrap, 1'b1);
    else          check("R2 channel is tick", got_wrap, 1'b0);
    repeat (d_ack) @(negedge clk);
    if (got_wrap) wrap_ack = 1'b1; else tick_ack = 1'b1;
    @(negedge clk);
    while (tick_req || wrap_req) @(negedge clk);
    repeat (d_rtz) @(negedge clk);
    check("R6 no early in_ack", in_ack, 1'b0);
    tick_ack = 1'b0; wrap_ack = 1'b0;
    @(negedge clk);
    while (!in_ack) @(negedge clk);
    repeat (d_wd) @(negedge clk);
    check("R7 in_ack held", in_ack, 1'b1);
    in_req = 1'b0;
    @(negedge clk);
    while (in_ack) @(negedge clk);
    events++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in_ack reset", in_ack, 1'b0);
    check("R1 tick_req reset", tick_req, 1'b0);
    check("R1 wrap_req reset", wrap_req, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", tick_req | wrap_req | in_ack, 1'b0);

    // Immediate responders: one full group of six.
    for (int i = 0; i < 6; i++) one_event(0, 0, 0);

    // Stray acknowledges while idle must not change anything.
    tick_ack = 1'b1; wrap_ack = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 no request from stray ack", tick_req | wrap_req | in_ack, 1'b0);
    tick_ack = 1'b0; wrap_ack = 1'b0;
    @(negedge clk);

    // Varied delays over more than two further groups.
    for (int i = 0; i < 14; i++) one_event(i % 4, (i * 3) % 5, (i * 7) % 3);

    // Mid-group stray acknowledges, then continue and check the channel order.
    tick_ack = 1'b1;
    repeat (2) @(negedge clk);
    tick_ack = 1'b0; wrap_ack = 1'b1;
    repeat (2) @(negedge clk);
    wrap_ack = 1'b0;
    check("R8 idle after stray ack", tick_req | wrap_req | in_ack, 1'b0);
    for (int i = 0; i < 8; i++) one_event(1, 2, 1);

    // Reset in the middle of a group: the next five events must go to tick.
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    events = 0;
    @(negedge clk);
    for (int i = 0; i < 7; i++) one_event(0, 1, 0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule